// File: doc/BRIEF.md
# CAN Receive Acceptance Filter and Buffer Allocator

This block sits after the bit-level receiver of a CAN controller. When a complete, error-free frame is presented for one cycle, it compares the frame identifier against sixteen message buffers in parallel. It then picks at most one buffer to store the frame. Each buffer holds a configured identifier, a format bit (standard or extended), a two-bit mask mode and a receive-complete flag. Two shared mask registers are available to the mask modes.

The choice is made in layers. First, a buffer accepts a frame only if the formats agree and its masked identifier bits match. Among the accepting buffers, those whose flag is clear or whose mode is exact-match are preferred. If no buffer is preferred, an occupied accepting buffer is overwritten. Lower index always wins. The stored frame replaces the buffer identifier and length code, and the data too unless the frame is a remote request.

The host uses a plain write port for buffer settings and masks, a write-one-to-clear vector for the flags, and a combinational read port for buffer contents.

Top module: `can_rx_filter`

## Requirements
- R1: After reset all receive-complete flags are 0, `wr_o` and `drop_o` are 0, and every buffer reads back identifier 0, standard format, mode 00, length 0 and data 0.
- R2: A frame with `frm_ext_i`=0 can only be accepted by buffers whose format bit is 0, and a frame with `frm_ext_i`=1 only by buffers whose format bit is 1.
- R3: The mask mode selects which identifier bits are compared (1 = compare). Code 00 compares every bit, 01 uses shared mask 0, 10 uses shared mask 1, and 11 compares none. A buffer accepts when all compared bits equal its stored identifier.
- R4: A standard frame is compared and stored on identifier bits [10:0] only. Bits [28:11] of the frame, the buffer identifier and the mask are ignored, and the stored identifier has bits [28:11] zero.
- R5: The preferred set is the accepting buffers whose flag is 0 or whose mode is 00. If it is not empty, the frame goes to its lowest-numbered member.
- R6: If the preferred set is empty and at least one buffer accepts, the frame goes to the lowest-numbered accepting buffer, overwriting it.
- R7: A data frame (`frm_rtr_i`=0) writes the identifier, length code and all 64 data bits to the chosen buffer.
- R8: A remote frame (`frm_rtr_i`=1) writes only the identifier and length code. The buffer's data keeps its previous value.
- R9: The cycle after `frm_valid_i` is sampled high with an accepting buffer, `wr_o` is 1 for exactly one cycle, `wr_idx_o` carries the chosen index, and that buffer's bit of `rc_o` is 1.
- R10: If no buffer accepts, `drop_o` pulses for one cycle the cycle after `frm_valid_i`. No buffer content or flag changes.
- R11: Writing 1 to bit i of `rc_clr_i` clears flag i on the next edge. A store to buffer i in the same cycle wins, and the flag ends up 1.
- R12: `cfg_we_i` writes the identifier (all 29 bits), format bit and mode of buffer `cfg_idx_i`. `msk_we_i` writes shared mask `msk_sel_i`. Both are visible from the next cycle. A frame store to the same buffer in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Buffer configuration write |
| cfg_idx_i | input | 4 | Buffer to configure |
| cfg_id_i | input | 29 | Configured identifier |
| cfg_ext_i | input | 1 | Configured format, 1 = extended |
| cfg_mode_i | input | 2 | Mask mode code |
| msk_we_i | input | 1 | Shared mask write |
| msk_sel_i | input | 1 | Shared mask select |
| msk_val_i | input | 29 | Shared mask value, 1 = compare |
| rc_clr_i | input | 16 | Write-one-to-clear for flags |
| frm_valid_i | input | 1 | Received frame valid, one cycle |
| frm_id_i | input | 29 | Received identifier |
| frm_ext_i | input | 1 | Received frame is extended |
| frm_rtr_i | input | 1 | Received frame is a remote request |
| frm_dlc_i | input | 4 | Received length code |
| frm_data_i | input | 64 | Received data bytes |
| rd_idx_i | input | 4 | Buffer to read back |
| rd_id_o | output | 29 | Read-back identifier |
| rd_ext_o | output | 1 | Read-back format bit |
| rd_mode_o | output | 2 | Read-back mask mode |
| rd_dlc_o | output | 4 | Read-back length code |
| rd_data_o | output | 64 | Read-back data |
| rc_o | output | 16 | Receive-complete flags |
| wr_o | output | 1 | Frame stored strobe |
| wr_idx_o | output | 4 | Index of buffer written |
| drop_o | output | 1 | Frame dropped strobe |

## Verification
A wrong hit or priority decision shows up one cycle after the frame. `wr_idx_o` names the wrong buffer, or `wr_o` and `drop_o` swap, and `rc_o` sets the wrong bit in the same cycle. A corrupted stored identifier shows only later. It changes which buffer a later frame selects, and the read-back port exposes it as soon as that buffer is read. Remote frames that clobber data show only through read-back after the store.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
  typedef enum logic [1:0] {
    MODE_EXACT = 2'b00,
    MODE_MASK0 = 2'b01,
    MODE_MASK1 = 2'b10,
    MODE_OPEN  = 2'b11
  } rxf_mode_e;
endpackage

// File: rtl/rxf_match.sv
module rxf_match import can_rxf_pkg::*; #(
  parameter int ID_W  = 29,
  parameter int STD_W = 11
) (
  input  logic [ID_W-1:0] cfg_id_i,
  input  logic            cfg_ext_i,
  input  rxf_mode_e       cfg_mode_i,
  input  logic [ID_W-1:0] mask0_i,
  input  logic [ID_W-1:0] mask1_i,
  input  logic [ID_W-1:0] frm_id_i,
  input  logic            frm_ext_i,
  output logic            hit_o
);
  localparam logic [ID_W-1:0] STD_KEEP = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};

  logic [ID_W-1:0] care;
  logic [ID_W-1:0] span;

  always_comb begin
    unique case (cfg_mode_i)
      MODE_EXACT: care = '1;
      MODE_MASK0: care = mask0_i;
      MODE_MASK1: care = mask1_i;
      default:    care = '0;
    endcase
  end

  assign span  = frm_ext_i ? '1 : STD_KEEP;
  assign hit_o = (cfg_ext_i == frm_ext_i) &&
                 (((cfg_id_i ^ frm_id_i) & care & span) == '0);
endmodule

// File: rtl/rxf_prio.sv
module rxf_prio #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     hit_i,
  input  logic [N-1:0]     pref_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     grant_o
);
  logic [N-1:0] cand;

  // preferred set first, fall back to any accepting buffer
  assign cand    = (|pref_i) ? pref_i : hit_i;
  assign grant_o = cand & (~cand + 1'b1);
  assign any_o   = |hit_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/can_rx_filter.sv
module can_rx_filter import can_rxf_pkg::*; #(
  parameter int NUM_BUF = 16,
  parameter int ID_W    = 29,
  parameter int STD_W   = 11,
  parameter int DLC_W   = 4,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [ID_W-1:0]   cfg_id_i,
  input  logic              cfg_ext_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              msk_we_i,
  input  logic              msk_sel_i,
  input  logic [ID_W-1:0]   msk_val_i,
  input  logic [NUM_BUF-1:0] rc_clr_i,
  input  logic              frm_valid_i,
  input  logic [ID_W-1:0]   frm_id_i,
  input  logic              frm_ext_i,
  input  logic              frm_rtr_i,
  input  logic [DLC_W-1:0]  frm_dlc_i,
  input  logic [DATA_W-1:0] frm_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ID_W-1:0]   rd_id_o,
  output logic              rd_ext_o,
  output logic [1:0]        rd_mode_o,
  output logic [DLC_W-1:0]  rd_dlc_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_BUF-1:0] rc_o,
  output logic              wr_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              drop_o
);
  localparam logic [ID_W-1:0] STD_KEEP = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};

  logic [ID_W-1:0]   id_q   [NUM_BUF];
  logic [NUM_BUF-1:0] ext_q;
  rxf_mode_e         mode_q [NUM_BUF];
  logic [DLC_W-1:0]  dlc_q  [NUM_BUF];
  logic [DATA_W-1:0] data_q [NUM_BUF];
  logic [NUM_BUF-1:0] rc_q;
  logic [ID_W-1:0]   mask_q [2];

  logic [NUM_BUF-1:0] hit, pref, grant;
  logic               any_hit, store;
  logic [IDX_W-1:0]   sel_idx;
  logic [ID_W-1:0]    id_in;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    rxf_match #(.ID_W(ID_W), .STD_W(STD_W)) u_match (
      .cfg_id_i  (id_q[g]),
      .cfg_ext_i (ext_q[g]),
      .cfg_mode_i(mode_q[g]),
      .mask0_i   (mask_q[0]),
      .mask1_i   (mask_q[1]),
      .frm_id_i  (frm_id_i),
      .frm_ext_i (frm_ext_i),
      .hit_o     (hit[g])
    );
    assign pref[g] = hit[g] & (~rc_q[g] | (mode_q[g] == MODE_EXACT));
  end

  rxf_prio #(.N(NUM_BUF), .IDX_W(IDX_W)) u_prio (
    .hit_i  (hit),
    .pref_i (pref),
    .any_o  (any_hit),
    .idx_o  (sel_idx),
    .grant_o(grant)
  );

  assign store = frm_valid_i & any_hit;
  assign id_in = frm_ext_i ? frm_id_i : (frm_id_i & STD_KEEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        id_q[i]   <= '0;
        mode_q[i] <= MODE_EXACT;
        dlc_q[i]  <= '0;
        data_q[i] <= '0;
      end
      ext_q     <= '0;
      rc_q      <= '0;
      mask_q[0] <= '0;
      mask_q[1] <= '0;
      wr_o      <= 1'b0;
      wr_idx_o  <= '0;
      drop_o    <= 1'b0;
    end else begin
      if (msk_we_i) mask_q[msk_sel_i] <= msk_val_i;
      for (int i = 0; i < NUM_BUF; i++) begin
        if (store && grant[i]) begin
          id_q[i]  <= id_in;
          dlc_q[i] <= frm_dlc_i;
          if (!frm_rtr_i) data_q[i] <= frm_data_i;
        end else if (cfg_we_i && (cfg_idx_i == IDX_W'(i))) begin
          id_q[i]   <= cfg_id_i;
          ext_q[i]  <= cfg_ext_i;
          mode_q[i] <= rxf_mode_e'(cfg_mode_i);
        end
      end
      // set beats clear
      rc_q     <= (rc_q & ~rc_clr_i) | (store ? grant : '0);
      wr_o     <= store;
      wr_idx_o <= store ? sel_idx : wr_idx_o;
      drop_o   <= frm_valid_i & ~any_hit;
    end
  end

  assign rc_o      = rc_q;
  assign rd_id_o   = id_q[rd_idx_i];
  assign rd_ext_o  = ext_q[rd_idx_i];
  assign rd_mode_o = mode_q[rd_idx_i];
  assign rd_dlc_o  = dlc_q[rd_idx_i];
  assign rd_data_o = data_q[rd_idx_i];

  // R9
  wr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(frm_valid_i));
  // R10
  drop_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> $past(frm_valid_i));
  // R10
  outcome_mutex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_o && drop_o));
  // R9
  outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> (wr_o || drop_o));
  // R9
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> rc_o[wr_idx_o]);
  // R8
  rtr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && $past(frm_rtr_i)) |-> (data_q[wr_idx_o] == $past(data_q[sel_idx])));
  // R10
  drop_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> (rc_o == ($past(rc_q) & ~$past(rc_clr_i))));
endmodule

// File: tb/tb_can_rx_filter.sv
module tb_can_rx_filter;
  localparam int NB = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_idx_i = '0;
  logic [28:0] cfg_id_i = '0;
  logic        cfg_ext_i = 1'b0;
  logic [1:0]  cfg_mode_i = '0;
  logic        msk_we_i = 1'b0;
  logic        msk_sel_i = 1'b0;
  logic [28:0] msk_val_i = '0;
  logic [15:0] rc_clr_i = '0;
  logic        frm_valid_i = 1'b0;
  logic [28:0] frm_id_i = '0;
  logic        frm_ext_i = 1'b0;
  logic        frm_rtr_i = 1'b0;
  logic [3:0]  frm_dlc_i = '0;
  logic [63:0] frm_data_i = '0;
  logic [3:0]  rd_idx_i = '0;
  logic [28:0] rd_id_o;
  logic        rd_ext_o;
  logic [1:0]  rd_mode_o;
  logic [3:0]  rd_dlc_o;
  logic [63:0] rd_data_o;
  logic [15:0] rc_o;
  logic        wr_o;
  logic [3:0]  wr_idx_o;
  logic        drop_o;

  always #10 clk_i = ~clk_i;

  can_rx_filter dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [28:0] m_id   [NB];
  logic        m_ext  [NB];
  logic [1:0]  m_mode [NB];
  logic [3:0]  m_dlc  [NB];
  logic [63:0] m_data [NB];
  logic [15:0] m_rc;
  logic [28:0] m_mask [2];
  logic [31:0] seed = 32'h1ACE_0F17;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic m_hit(input int b, input logic [28:0] fid, input logic fext);
    logic [28:0] care;
    logic [28:0] span;
    case (m_mode[b])
      2'd0: care = '1;
      2'd1: care = m_mask[0];
      2'd2: care = m_mask[1];
      default: care = '0;
    endcase
    span = fext ? 29'h1FFF_FFFF : 29'h7FF;
    return (m_ext[b] == fext) && (((m_id[b] ^ fid) & care & span) == '0);
  endfunction

  task automatic cfg_buf(input int b, input logic [28:0] id, input logic ext, input logic [1:0] mode);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = 4'(b); cfg_id_i = id; cfg_ext_i = ext; cfg_mode_i = mode;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    m_id[b] = id; m_ext[b] = ext; m_mode[b] = mode;
    rd_idx_i = 4'(b);
    #1;
    chk(rd_id_o == id, "R12", "cfg id", 64'(rd_id_o), 64'(id));
    chk(rd_ext_o == ext && rd_mode_o == mode, "R12", "cfg ext/mode",
        64'({rd_ext_o, rd_mode_o}), 64'({ext, mode}));
  endtask

  task automatic set_mask(input logic sel, input logic [28:0] val);
    @(negedge clk_i);
    msk_we_i = 1'b1; msk_sel_i = sel; msk_val_i = val;
    @(negedge clk_i);
    msk_we_i = 1'b0;
    m_mask[sel] = val;
  endtask

  task automatic clear_flags(input logic [15:0] m);
    @(negedge clk_i);
    rc_clr_i = m;
    @(negedge clk_i);
    rc_clr_i = '0;
    m_rc &= ~m;
    chk(rc_o == m_rc, "R11", "flags after clear", 64'(rc_o), 64'(m_rc));
  endtask

  task automatic check_all(input string req);
    for (int b = 0; b < NB; b++) begin
      rd_idx_i = 4'(b);
      #1;
      chk(rd_id_o == m_id[b] && rd_dlc_o == m_dlc[b] && rd_data_o == m_data[b],
          req, "buffer contents", rd_data_o ^ 64'(rd_id_o), m_data[b] ^ 64'(m_id[b]));
    end
  endtask

  task automatic send_frame(input logic [28:0] id, input logic ext, input logic rtr,
                            input logic [3:0] dlc, input logic [63:0] data,
                            input logic [15:0] clr, input string tag);
    logic [15:0] hitv, prefv, cand;
    int idx;
    logic any;
    string req;
    logic [28:0] sid;
    hitv = '0; prefv = '0;
    for (int b = 0; b < NB; b++) begin
      hitv[b]  = m_hit(b, id, ext);
      prefv[b] = hitv[b] && (!m_rc[b] || m_mode[b] == 2'd0);
    end
    any  = |hitv;
    cand = (|prefv) ? prefv : hitv;
    idx  = 0;
    for (int b = NB - 1; b >= 0; b--) if (cand[b]) idx = b;
    if (tag != "") req = tag;
    else req = (|prefv) ? "R5" : (any ? "R6" : "R10");
    sid = ext ? id : (id & 29'h7FF);

    @(negedge clk_i);
    frm_valid_i = 1'b1; frm_id_i = id; frm_ext_i = ext; frm_rtr_i = rtr;
    frm_dlc_i = dlc; frm_data_i = data; rc_clr_i = clr;
    @(negedge clk_i);
    frm_valid_i = 1'b0; rc_clr_i = '0;
    m_rc = (m_rc & ~clr) | (any ? (16'd1 << idx) : 16'd0);
    chk(wr_o == any && drop_o == !any, req, "wr/drop", 64'({wr_o, drop_o}), 64'({any, !any}));
    if (any) begin
      chk(wr_idx_o == 4'(idx), req, "index", 64'(wr_idx_o), 64'(idx));
      m_id[idx]  = sid;
      m_dlc[idx] = dlc;
      if (!rtr) m_data[idx] = data;
      rd_idx_i = 4'(idx);
      #1;
      chk(rd_id_o == sid && rd_dlc_o == dlc, "R7", "stored id/dlc",
          64'({rd_id_o, rd_dlc_o}), 64'({sid, dlc}));
      chk(rd_data_o == m_data[idx], rtr ? "R8" : "R7", "stored data", rd_data_o, m_data[idx]);
    end
    chk(rc_o == m_rc, "R11", "flags", 64'(rc_o), 64'(m_rc));
    @(negedge clk_i);
    chk(!wr_o && !drop_o, "R9", "strobe one cycle", 64'({wr_o, drop_o}), 64'd0);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_id[b] = '0; m_ext[b] = 1'b0; m_mode[b] = 2'd0; m_dlc[b] = '0; m_data[b] = '0;
    end
    m_rc = '0; m_mask[0] = '0; m_mask[1] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(rc_o == '0 && !wr_o && !drop_o, "R1", "reset outputs",
        64'({rc_o, wr_o, drop_o}), 64'd0);
    check_all("R1");

    // format gating: all buffers standard, extended frame drops
    send_frame(29'h0, 1'b1, 1'b0, 4'd8, 64'h1111_2222_3333_4444, '0, "R2");
    check_all("R10");
    // upper bits ignored for standard frames
    send_frame(29'h1FFF_F800, 1'b0, 1'b0, 4'd3, 64'hA5A5_0000_1234_5678, '0, "R4");
    // exact mode stays preferred with flag set
    send_frame(29'h0, 1'b0, 1'b0, 4'd2, 64'h0BAD_F00D_0000_0001, '0, "R5");

    set_mask(1'b0, 29'h7F0);
    cfg_buf(0, 29'h100, 1'b0, 2'd1);
    cfg_buf(1, 29'h007, 1'b0, 2'd3);
    clear_flags(16'hFFFF);
    send_frame(29'h10F, 1'b0, 1'b0, 4'd8, 64'hDEAD_BEEF_CAFE_0001, '0, "R3");
    send_frame(29'h20F, 1'b0, 1'b0, 4'd8, 64'hDEAD_BEEF_CAFE_0002, '0, "R3");
    send_frame(29'h20F, 1'b0, 1'b0, 4'd8, 64'hDEAD_BEEF_CAFE_0003, '0, "R6");
    cfg_buf(2, 29'h0, 1'b0, 2'd3);
    send_frame(29'h20F, 1'b0, 1'b0, 4'd1, 64'hDEAD_BEEF_CAFE_0004, '0, "R5");
    send_frame(29'h20F, 1'b0, 1'b1, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, '0, "");
    // store and clear on the same buffer in one cycle
    send_frame(29'h20F, 1'b0, 1'b0, 4'd4, 64'h0123_4567_89AB_CDEF, 16'h0002, "R11");

    // sweep configuration
    set_mask(1'b0, 29'h1FFF_FFFC);
    set_mask(1'b1, 29'h1FFF_FF0F);
    for (int b = 0; b < NB; b++)
      cfg_buf(b, (b >= 8 ? 29'h123_4500 : 29'h120) + 29'(b % 3), b >= 8, 2'((b % 8) / 2));
    clear_flags(16'hFFFF);

    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      int b;
      logic [28:0] fid;
      logic fext;
      logic [15:0] clr;
      r = rnd();
      b = int'(r[3:0]);
      fext = (r[6:4] == 3'd0) ? !m_ext[b] : m_ext[b];
      fid = m_id[b] ^ (r[7] ? (29'(r[15:8]) & 29'hF3) : 29'h0);
      clr = (r[18:16] == 3'd0) ? 16'(rnd()) : 16'h0;
      send_frame(fid, fext, r[20:19] == 2'd0, 4'(r[24:21] % 9),
                 {rnd(), rnd()}, clr, "");
      if (n % 60 == 59) begin
        r = rnd();
        cfg_buf(int'(r[3:0]), m_id[r[7:4]], r[8], r[10:9]);
        check_all("R10");
      end
    end
    check_all("R7");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule